// File: doc/BRIEF.md
# External Status Interrupt Latch

This block is the per-channel status-change interrupt logic of a serial communications controller. It watches six external or internal conditions: break/abort, transmit underrun/end of message, clear-to-send, sync/hunt, carrier detect and a baud-rate counter reaching zero. It raises a pending status interrupt when any enabled condition changes level, in either direction. Two further live conditions, transmit buffer empty and receive character available, are shown in the status byte but never cause this interrupt.

Software programs the block through a byte-wide register write port: a per-source enable register, a channel enable bit, a master enable bit, a channel reset code and a command code that clears the pending interrupt. The status byte normally follows the inputs directly. Once an interrupt is pending, the six watched bits freeze at the values seen when it was raised. Clearing the interrupt releases them. A level that moved during the frozen period is compared against the frozen value, so the change raises a new interrupt instead of being lost.

Top module: `ext_status_latch`

## Requirements
- R1: `stat_rr0` maps bit 7 break/abort, 6 underrun/EOM, 5 CTS, 4 sync/hunt, 3 DCD, 2 transmit buffer empty, 1 zero count, 0 receive character available. With nothing pending, every bit equals its input in the same cycle.
- R2: A write with `wr_addr` = 15 loads the source enables. Data bits 7, 6, 5, 4, 3 and 1 enable the matching `stat_rr0` bits, and data bits 2 and 0 are ignored.
- R3: When the channel enable (register 1, bit 0) is set, a rising or a falling level change of an enabled source sets `stat_pend` at the next clock edge.
- R4: A change on a source whose enable is clear does not set `stat_pend`. A change of any source while the channel enable is clear does not set it either. Setting the channel enable later does not act on changes that happened while it was clear.
- R5: While `stat_pend` is high, `stat_rr0` bits 7..3 and 1 hold the values captured at the edge that set it. Bits 2 and 0 keep following their inputs.
- R6: A write to register 0 with data bits 5:3 = 010 clears `stat_pend` at that clock edge. Other command codes, and the same data written to another register, leave it set.
- R7: After a clear, a watched bit whose input differs from its captured value sets `stat_pend` again one clock edge later. If no input differs, `stat_pend` stays low.
- R8: `irq` is high exactly when `stat_pend` is high and the master enable (register 9, bit 3) is set.
- R9: A write to register 9 with data bits 7:6 not 00, or `rst_n` low, clears `stat_pend`, the source enables, the channel enable and the master enable.
- R10: Changes of the transmit buffer empty and receive character available inputs never set `stat_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register number written |
| wr_data | input | 8 | Register write data |
| brk_in | input | 1 | Break/abort condition |
| txund_in | input | 1 | Transmit underrun/end of message |
| cts_in | input | 1 | Clear-to-send level |
| hunt_in | input | 1 | Sync/hunt level |
| dcd_in | input | 1 | Carrier detect level |
| txe_in | input | 1 | Transmit buffer empty |
| zc_in | input | 1 | Baud counter zero count |
| rxa_in | input | 1 | Receive character available |
| stat_rr0 | output | 8 | Status byte, live or frozen |
| stat_pend | output | 1 | Status interrupt pending |
| irq | output | 1 | Interrupt request after master enable |

## Verification
The status byte is combinational, so the bench reads it one nanosecond after it changes an input and before the next clock edge. Pending, re-raise, clears, resets and enable updates are all due at the first clock edge after the stimulus or write. The re-raise after a clear comes one edge later still, and `irq` follows `stat_pend` in the same cycle. Inputs are driven two nanoseconds after a rising edge, and every registered result is sampled two nanoseconds after the edge at which it is due.

// File: rtl/ext_status_latch.sv
module ext_status_latch #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          brk_in,
  input  logic          txund_in,
  input  logic          cts_in,
  input  logic          hunt_in,
  input  logic          dcd_in,
  input  logic          txe_in,
  input  logic          zc_in,
  input  logic          rxa_in,
  output logic [DW-1:0] stat_rr0,
  output logic          stat_pend,
  output logic          irq
);
  localparam logic [AW-1:0] REG_CMD = AW'(0);
  localparam logic [AW-1:0] REG_IEN = AW'(1);
  localparam logic [AW-1:0] REG_MST = AW'(9);
  localparam logic [AW-1:0] REG_SRC = AW'(15);
  localparam logic [DW-1:0] WATCH   = DW'(8'hFA);
  localparam logic [2:0]    CMD_CLR = 3'b010;

  logic [DW-1:0] live, snap_q, en_q;
  logic pend_q, sie_q, mie_q;

  assign live = DW'({brk_in, txund_in, cts_in, hunt_in, dcd_in, txe_in, zc_in, rxa_in});

  wire clr_cmd = wr_en && (wr_addr == REG_CMD) && (wr_data[5:3] == CMD_CLR);
  wire ch_rst  = wr_en && (wr_addr == REG_MST) && (wr_data[7:6] != 2'b00);
  wire hit     = sie_q && (|((live ^ snap_q) & en_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sie_q  <= 1'b0;
      mie_q  <= 1'b0;
      en_q   <= '0;
      snap_q <= '0;
    end else if (ch_rst) begin
      pend_q <= 1'b0;
      sie_q  <= 1'b0;
      mie_q  <= 1'b0;
      en_q   <= '0;
      snap_q <= live;
    end else begin
      if (wr_en && wr_addr == REG_IEN) sie_q <= wr_data[0];
      if (wr_en && wr_addr == REG_MST) mie_q <= wr_data[3];
      if (wr_en && wr_addr == REG_SRC) en_q  <= wr_data & WATCH;
      if (pend_q) begin
        if (clr_cmd) pend_q <= 1'b0;
      end else begin
        snap_q <= live;
        if (hit) pend_q <= 1'b1;
      end
    end
  end

  assign stat_rr0  = pend_q ? ((snap_q & WATCH) | (live & ~WATCH)) : live;
  assign stat_pend = pend_q;
  assign irq       = pend_q & mie_q;
endmodule

// File: rtl/ext_status_latch_chk.sv
module ext_status_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] stat_rr0,
  input logic       stat_pend,
  input logic       irq,
  input logic       sie_q,
  input logic       mie_q
);
  logic clr_w, rst_w;
  assign clr_w = wr_en && wr_addr == 4'd0 && wr_data[5:3] == 3'b010;
  assign rst_w = wr_en && wr_addr == 4'd9 && wr_data[7:6] != 2'b00;

  a_r6_clear_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pend && clr_w) |=> !stat_pend);

  a_r5_frozen_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pend && !clr_w && !rst_w) |=> $stable(stat_rr0 & 8'hFA));

  a_r9_chan_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_w |=> (!stat_pend && !irq));

  a_r3_raise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_pend) |-> $past(sie_q));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_pend && mie_q));
endmodule

bind ext_status_latch ext_status_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .stat_rr0(stat_rr0), .stat_pend(stat_pend), .irq(irq), .sie_q(sie_q), .mie_q(mie_q)
);

// File: tb/ext_status_latch_test.sv
module ext_status_latch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] ext = '0;
  logic [7:0] stat_rr0;
  logic stat_pend, irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_status_latch uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .brk_in(ext[7]), .txund_in(ext[6]), .cts_in(ext[5]), .hunt_in(ext[4]),
    .dcd_in(ext[3]), .txe_in(ext[2]), .zc_in(ext[1]), .rxa_in(ext[0]),
    .stat_rr0(stat_rr0), .stat_pend(stat_pend), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic trig;
    ext[5] = ~ext[5];
    tick();
  endtask

  task automatic t_reset_state;
    check("R1 reset view", stat_rr0, 8'h00);
    check("R9 reset pend", {7'd0, stat_pend}, 8'd0);
    check("R9 reset irq", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_live_view;
    logic [7:0] pats [4] = '{8'hA5, 8'h5A, 8'hFF, 8'h00};
    foreach (pats[i]) begin
      ext = pats[i];
      #1 check("R1 live map", stat_rr0, pats[i]);
      tick();
      check("R4 no enables no pend", {7'd0, stat_pend}, 8'd0);
    end
  endtask

  task automatic t_setup;
    wr(4'd15, 8'hFF);
    wr(4'd1, 8'h01);
    wr(4'd9, 8'h08);
    check("R3 setup quiet", {7'd0, stat_pend}, 8'd0);
  endtask

  task automatic t_edges;
    int bits [6] = '{7, 6, 5, 4, 3, 1};
    foreach (bits[i]) begin
      int b = bits[i];
      ext[b] = 1'b1;
      tick();
      check("R3 rising edge pend", {7'd0, stat_pend}, 8'd1);
      check("R8 irq with master", {7'd0, irq}, 8'd1);
      ext[b] = 1'b0;
      #1 check("R5 frozen bit", {7'd0, stat_rr0[b]}, 8'd1);
      wr(4'd0, 8'h10);
      check("R6 clear", {7'd0, stat_pend}, 8'd0);
      check("R5 live after clear", {7'd0, stat_rr0[b]}, 8'd0);
      tick();
      check("R7 re-raise", {7'd0, stat_pend}, 8'd1);
      wr(4'd0, 8'h10);
      tick();
      check("R7 no repeat", {7'd0, stat_pend}, 8'd0);
    end
  endtask

  task automatic t_fall;
    ext[3] = 1'b1;
    tick();
    check("R3 dcd rise", {7'd0, stat_pend}, 8'd1);
    wr(4'd0, 8'h10);
    tick();
    check("R7 equal stays low", {7'd0, stat_pend}, 8'd0);
    ext[3] = 1'b0;
    tick();
    check("R3 falling edge pend", {7'd0, stat_pend}, 8'd1);
    check("R5 captured fall", stat_rr0 & 8'hFA, 8'h00);
    wr(4'd0, 8'h10);
  endtask

  task automatic t_live_bits;
    ext[2] = 1'b1; ext[0] = 1'b1;
    tick();
    check("R10 txe/rxa no pend", {7'd0, stat_pend}, 8'd0);
    trig();
    check("R3 cts pend", {7'd0, stat_pend}, 8'd1);
    ext[2] = 1'b0; ext[0] = 1'b0;
    #1 check("R5 bits 2,0 live", stat_rr0 & 8'h05, 8'h00);
    wr(4'd0, 8'h10);
    tick();
    check("R10 no re-raise", {7'd0, stat_pend}, 8'd0);
  endtask

  task automatic t_masking;
    wr(4'd15, 8'h20);
    ext[3] = ~ext[3];
    tick();
    check("R4 disabled dcd", {7'd0, stat_pend}, 8'd0);
    wr(4'd15, 8'h05);
    ext[2] = ~ext[2]; ext[0] = ~ext[0]; ext[1] = ~ext[1];
    tick();
    check("R2 bits 2,0 ignored", {7'd0, stat_pend}, 8'd0);
    trig();
    check("R2 cts not enabled", {7'd0, stat_pend}, 8'd0);
    wr(4'd15, 8'h20);
    trig();
    check("R2 cts enabled", {7'd0, stat_pend}, 8'd1);
    wr(4'd0, 8'h10);
    wr(4'd1, 8'h00);
    trig();
    check("R4 sie off", {7'd0, stat_pend}, 8'd0);
    wr(4'd1, 8'h01);
    tick();
    check("R4 no stale event", {7'd0, stat_pend}, 8'd0);
  endtask

  task automatic t_other_cmd;
    trig();
    wr(4'd0, 8'h08);
    check("R6 code 001 keeps", {7'd0, stat_pend}, 8'd1);
    wr(4'd0, 8'h18);
    check("R6 code 011 keeps", {7'd0, stat_pend}, 8'd1);
    wr(4'd2, 8'h10);
    check("R6 other reg keeps", {7'd0, stat_pend}, 8'd1);
    wr(4'd0, 8'h10);
    check("R6 clear", {7'd0, stat_pend}, 8'd0);
  endtask

  task automatic t_master;
    wr(4'd9, 8'h00);
    trig();
    check("R8 pend w/o master", {7'd0, stat_pend}, 8'd1);
    check("R8 irq low", {7'd0, irq}, 8'd0);
    wr(4'd9, 8'h08);
    check("R8 irq follows master", {7'd0, irq}, 8'd1);
    wr(4'd0, 8'h10);
    check("R8 irq drops", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_chreset;
    trig();
    check("R9 pend before", {7'd0, stat_pend}, 8'd1);
    wr(4'd9, 8'hC0);
    check("R9 reset pend", {7'd0, stat_pend}, 8'd0);
    check("R9 reset irq", {7'd0, irq}, 8'd0);
    trig();
    check("R9 enables cleared", {7'd0, stat_pend}, 8'd0);
    wr(4'd15, 8'h20); wr(4'd1, 8'h01); wr(4'd9, 8'h08);
    trig();
    wr(4'd9, 8'h48);
    check("R9 code 01 reset", {7'd0, stat_pend}, 8'd0);
    trig();
    check("R9 sie cleared", {7'd0, stat_pend}, 8'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    t_reset_state();
    t_live_view();
    t_setup();
    t_edges();
    t_fall();
    t_live_bits();
    t_masking();
    t_other_cmd();
    t_master();
    t_chreset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule